// File: doc/BRIEF.md
# SD Host Interrupt Status Unit

This block gathers event pulses from an SD/MMC host core into two byte-wide status registers. It combines them into a single registered interrupt line. Software reaches everything through a small byte-addressed register port with a write strobe, an address, write data and combinational read data. Software reads a status byte and acknowledges events by writing ones to the bits it has handled.

Eight completion and error pulses arrive for status byte 1, and four arrive for the upper half of status byte 0. Three card levels are also shown in status byte 0: write protect, detect through DAT3, and detect through a dedicated pin. These levels pass through a synchronizer and are read live. Two mask bytes choose which latched events may raise the interrupt. A 16-bit configuration register holds a global interrupt enable, the card-detect source and polarity selections, and the block size minus one. Neighbouring logic uses the configuration fields; the interrupt logic uses only the enable bit.

Top module: `sdh_irq_status`

## Requirements
- R1: After reset, every readable register returns 0x00 and `irq` is low.
- R2: A pulse on `ev_byte1[i]` sets status byte 1 (address 1) bit i after the next clock edge. A pulse on `ev_byte0[i]` sets status byte 0 (address 0) bit 4+i. A bit that has been set stays set until software clears it.
- R3: A write to address 0 or 1 clears each latched event bit whose write-data bit is 1. Bits written with 0 keep their value.
- R4: If an event pulse and a write-one-to-clear reach the same bit in the same cycle, the bit ends up set.
- R5: Status byte 0 bit 1 shows `lvl_wp`, bit 2 shows `lvl_cd_dat3` and bit 3 shows `lvl_cd_gpi`. Each appears SYNC_STAGES clock edges after the input changes. Writes do not affect these bits, and bit 0 always reads 0.
- R6: Mask byte 0 (address 2) stores only bits 7..4. Mask byte 1 (address 3) stores only bits 7..1. The other mask bits read 0.
- R7: One clock edge after the status and mask state, `irq` equals configuration bit 15 ANDed with the OR over both bytes of (status AND mask). Status byte 1 bit 0 (the SDIO event) never raises `irq`.
- R8: The configuration register sits at address 4 (bits 7..0) and address 5 (bits 15..8). The outputs are driven from it as follows:
  - `blk_len_m1` = bits 10..0
  - `cd_pol_high` = bit 12
  - `cd_use_gpi` = bit 13
  - `cd_use_dat3` = bit 14
  - global interrupt enable = bit 15
- R9: Addresses 6 and above read 0x00. Writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| ev_byte0 | input | 4 | Event pulses for status byte 0 bits 7..4 |
| ev_byte1 | input | 8 | Event pulses for status byte 1 bits 7..0 |
| lvl_wp | input | 1 | Write-protect level (asynchronous) |
| lvl_cd_dat3 | input | 1 | DAT3 card-detect level (asynchronous) |
| lvl_cd_gpi | input | 1 | Pin card-detect level (asynchronous) |
| irq | output | 1 | Registered interrupt request |
| blk_len_m1 | output | 11 | Block size minus one |
| cd_use_gpi | output | 1 | Selects pin card detect |
| cd_use_dat3 | output | 1 | Selects DAT3 card detect |
| cd_pol_high | output | 1 | Card-detect polarity is active high |

## Verification
The bench builds the block with SYNC_STAGES = 2 and ADDR_W = 3. With a two-stage synchronizer, the level delay in R5 can be observed within a few cycles. A three-bit address reaches the two unmapped slots, so the R9 behaviour is exercised alongside every mapped register. Random writes land on all eight addresses while sparse event pulses run in parallel. This makes event-versus-clear collisions and enable toggling frequent.

// File: rtl/sdh_irq_pkg.sv
package sdh_irq_pkg;
  localparam int BYTE_W = 8;
  localparam int CFG_W  = 16;
  // register map
  localparam int A_STAT0 = 0;
  localparam int A_STAT1 = 1;
  localparam int A_MASK0 = 2;
  localparam int A_MASK1 = 3;
  localparam int A_CFGLO = 4;
  localparam int A_CFGHI = 5;
  // storable bits of each byte
  localparam logic [7:0] ST0_EVT_BITS  = 8'hF0;
  localparam logic [7:0] ST1_EVT_BITS  = 8'hFF;
  localparam logic [7:0] MASK0_BITS    = 8'hF0;
  localparam logic [7:0] MASK1_BITS    = 8'hFE;
  // configuration fields
  localparam int CFG_LEN_W  = 11;
  localparam int CFG_POL    = 12;
  localparam int CFG_GPI    = 13;
  localparam int CFG_DAT3   = 14;
  localparam int CFG_IRQ_EN = 15;
endpackage

// File: rtl/sdh_level_sync.sv
module sdh_level_sync #(
  parameter int N_BITS = 3,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_BITS-1:0] d,
  output logic [N_BITS-1:0] q
);
  logic [N_BITS-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) chain[s] <= '0;
      else if (s == 0) chain[s] <= d;
      else chain[s] <= chain[(s == 0) ? 0 : s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/sdh_w1c_byte.sv
module sdh_w1c_byte #(
  parameter logic [7:0] KEEP = 8'hFF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] set,
  input  logic       clr_en,
  input  logic [7:0] clr_bits,
  output logic [7:0] q
);
  logic [7:0] clr_v;

  assign clr_v = clr_en ? clr_bits : 8'h00;

  // set term is ORed last so a same-cycle event beats the clear
  always_ff @(posedge clk) begin
    if (!rst_n) q <= 8'h00;
    else        q <= KEEP & ((q & ~clr_v) | set);
  end
endmodule

// File: rtl/sdh_rw_byte.sv
module sdh_rw_byte #(
  parameter logic [7:0] KEEP = 8'hFF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [7:0] wdata,
  output logic [7:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)  q <= 8'h00;
    else if (we) q <= wdata & KEEP;
  end
endmodule

// File: rtl/sdh_irq_status.sv
module sdh_irq_status
  import sdh_irq_pkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_we,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [7:0]           reg_wdata,
  output logic [7:0]           reg_rdata,
  input  logic [3:0]           ev_byte0,
  input  logic [7:0]           ev_byte1,
  input  logic                 lvl_wp,
  input  logic                 lvl_cd_dat3,
  input  logic                 lvl_cd_gpi,
  output logic                 irq,
  output logic [CFG_LEN_W-1:0] blk_len_m1,
  output logic                 cd_use_gpi,
  output logic                 cd_use_dat3,
  output logic                 cd_pol_high
);
  localparam int N_LVL  = 3;
  localparam int N_CFGB = CFG_W / BYTE_W;

  logic [N_LVL-1:0] lvl_raw, lvl_s;
  logic [7:0]       st0_q, st1_q, mask0_q, mask1_q;
  logic [CFG_W-1:0] cfg_q;
  logic             hit;

  function automatic logic sel(input logic [ADDR_W-1:0] a, input int n);
    return reg_we && (int'(a) == n);
  endfunction

  assign lvl_raw = {lvl_cd_gpi, lvl_cd_dat3, lvl_wp};

  sdh_level_sync #(.N_BITS(N_LVL), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(lvl_raw), .q(lvl_s)
  );

  sdh_w1c_byte #(.KEEP(ST0_EVT_BITS)) u_st0 (
    .clk(clk), .rst_n(rst_n), .set({ev_byte0, 4'h0}),
    .clr_en(sel(reg_addr, A_STAT0)), .clr_bits(reg_wdata), .q(st0_q)
  );

  sdh_w1c_byte #(.KEEP(ST1_EVT_BITS)) u_st1 (
    .clk(clk), .rst_n(rst_n), .set(ev_byte1),
    .clr_en(sel(reg_addr, A_STAT1)), .clr_bits(reg_wdata), .q(st1_q)
  );

  sdh_rw_byte #(.KEEP(MASK0_BITS)) u_mask0 (
    .clk(clk), .rst_n(rst_n), .we(sel(reg_addr, A_MASK0)),
    .wdata(reg_wdata), .q(mask0_q)
  );

  sdh_rw_byte #(.KEEP(MASK1_BITS)) u_mask1 (
    .clk(clk), .rst_n(rst_n), .we(sel(reg_addr, A_MASK1)),
    .wdata(reg_wdata), .q(mask1_q)
  );

  for (genvar b = 0; b < N_CFGB; b++) begin : g_cfg
    sdh_rw_byte #(.KEEP(8'hFF)) u_cfg (
      .clk(clk), .rst_n(rst_n), .we(sel(reg_addr, A_CFGLO + b)),
      .wdata(reg_wdata), .q(cfg_q[b*BYTE_W +: BYTE_W])
    );
  end

  // bit 0 of status byte 1 (SDIO) is never enabled by its mask
  assign hit = |(st0_q & mask0_q) | |(st1_q & mask1_q);

  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= cfg_q[CFG_IRQ_EN] & hit;
  end

  always_comb begin
    case (int'(reg_addr))
      A_STAT0: reg_rdata = st0_q | {4'h0, lvl_s, 1'b0};
      A_STAT1: reg_rdata = st1_q;
      A_MASK0: reg_rdata = mask0_q;
      A_MASK1: reg_rdata = mask1_q;
      A_CFGLO: reg_rdata = cfg_q[7:0];
      A_CFGHI: reg_rdata = cfg_q[15:8];
      default: reg_rdata = 8'h00;
    endcase
  end

  assign blk_len_m1  = cfg_q[CFG_LEN_W-1:0];
  assign cd_pol_high = cfg_q[CFG_POL];
  assign cd_use_gpi  = cfg_q[CFG_GPI];
  assign cd_use_dat3 = cfg_q[CFG_DAT3];
endmodule

// File: rtl/sdh_irq_status_chk.sv
module sdh_irq_status_chk #(
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          irq,
  input logic          cfg_en,
  input logic [7:0]    st1,
  input logic [7:0]    mask1,
  input logic [7:0]    ev1,
  input logic          we,
  input logic [AW-1:0] addr,
  input logic [7:0]    wdata
);
  logic clr1;
  assign clr1 = we && (addr == AW'(1));

  AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev1 != 8'h00) |=> ((st1 & $past(ev1)) == $past(ev1))); // R2

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr1 && ev1 == 8'h00) |=> ((st1 & $past(wdata)) == 8'h00)); // R3

  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr1 && (ev1 & wdata) != 8'h00) |=> ((st1 & $past(ev1 & wdata)) == $past(ev1 & wdata))); // R4

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(cfg_en)); // R7

  AST_IRQ_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en && (st1 & mask1) != 8'h00) |=> irq); // R7
endmodule

bind sdh_irq_status sdh_irq_status_chk #(.AW(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .cfg_en(cfg_q[15]),
  .st1(st1_q), .mask1(mask1_q), .ev1(ev_byte1),
  .we(reg_we), .addr(reg_addr), .wdata(reg_wdata)
);

// File: tb/sim_sdh_irq_status.sv
module sim_sdh_irq_status;
  localparam int CLK_P = 10;
  localparam int AW    = 3;
  localparam int SYNC  = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_we = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [7:0]    reg_wdata = 8'h00;
  logic [7:0]    reg_rdata;
  logic [3:0]    ev_byte0 = 4'h0;
  logic [7:0]    ev_byte1 = 8'h00;
  logic [2:0]    lv = 3'b000; // {gpi, dat3, wp}
  logic          irq;
  logic [10:0]   blk_len_m1;
  logic          cd_use_gpi, cd_use_dat3, cd_pol_high;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  sdh_irq_status #(.ADDR_W(AW), .SYNC_STAGES(SYNC)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_byte0(ev_byte0),
    .ev_byte1(ev_byte1), .lvl_wp(lv[0]), .lvl_cd_dat3(lv[1]),
    .lvl_cd_gpi(lv[2]), .irq(irq), .blk_len_m1(blk_len_m1),
    .cd_use_gpi(cd_use_gpi), .cd_use_dat3(cd_use_dat3),
    .cd_pol_high(cd_pol_high)
  );

  // reference model built from the requirements
  logic [3:0]  m_st0;
  logic [7:0]  m_st1, m_m0, m_m1;
  logic [15:0] m_cfg;
  logic [2:0]  m_s1, m_s2;
  logic        m_irq;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st0 <= '0; m_st1 <= '0; m_m0 <= '0; m_m1 <= '0;
      m_cfg <= '0; m_s1 <= '0; m_s2 <= '0; m_irq <= 1'b0;
    end else begin
      m_s1 <= lv;
      m_s2 <= m_s1;
      m_irq <= m_cfg[15] & (|({m_st0, 4'h0} & m_m0) | |(m_st1 & m_m1));
      m_st0 <= (m_st0 & ~((reg_we && reg_addr == 0) ? reg_wdata[7:4] : 4'h0)) | ev_byte0;
      m_st1 <= (m_st1 & ~((reg_we && reg_addr == 1) ? reg_wdata : 8'h00)) | ev_byte1;
      if (reg_we && reg_addr == 2) m_m0 <= reg_wdata & 8'hF0;
      if (reg_we && reg_addr == 3) m_m1 <= reg_wdata & 8'hFE;
      if (reg_we && reg_addr == 4) m_cfg[7:0]  <= reg_wdata;
      if (reg_we && reg_addr == 5) m_cfg[15:8] <= reg_wdata;
    end
  end

  function automatic logic [7:0] rd_exp(input logic [AW-1:0] a);
    case (a)
      0: return {m_st0, m_s2, 1'b0};
      1: return m_st1;
      2: return m_m0;
      3: return m_m1;
      4: return m_cfg[7:0];
      5: return m_cfg[15:8];
      default: return 8'h00;
    endcase
  endfunction

  function automatic string tag_of(input logic [AW-1:0] a);
    case (a)
      0: return "R2 R5";
      1: return "R3 R4";
      2, 3: return "R6";
      4, 5: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", req, got, exp, $time);
    end
  endtask

  // drive one cycle at the falling edge, then check the settled outputs
  task automatic step(input logic we, input logic [AW-1:0] a, input logic [7:0] wd,
                      input logic [3:0] e0, input logic [7:0] e1);
    @(negedge clk);
    reg_we = we; reg_addr = a; reg_wdata = wd; ev_byte0 = e0; ev_byte1 = e1;
    #1;
    chk(tag_of(a), {8'h00, reg_rdata}, {8'h00, rd_exp(a)});
    chk("R7", {15'h0, irq}, {15'h0, m_irq});
  endtask

  task automatic idle_rd(input logic [AW-1:0] a);
    step(1'b0, a, 8'h00, 4'h0, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    for (int a = 0; a < 8; a++) begin
      reg_addr = AW'(a); #1;
      chk("R1", {8'h00, reg_rdata}, 16'h0000);
    end
    chk("R1", {15'h0, irq}, 16'h0000);
    @(negedge clk); rst_n = 1'b1;

    // R7 enable, R6 mask bit for command done
    step(1'b1, 3'd5, 8'h80, 4'h0, 8'h00);
    step(1'b1, 3'd3, 8'h02, 4'h0, 8'h00);
    step(1'b0, 3'd1, 8'h00, 4'h0, 8'h02);
    idle_rd(3'd1);
    chk("R2", {8'h00, reg_rdata}, 16'h0002);
    chk("R7 one edge later", {15'h0, irq}, 16'h0000);
    idle_rd(3'd1);
    chk("R7", {15'h0, irq}, 16'h0001);
    // R4 clear collides with event
    step(1'b1, 3'd1, 8'h02, 4'h0, 8'h02);
    idle_rd(3'd1);
    chk("R4", {8'h00, reg_rdata}, 16'h0002);
    // R3 clear alone, other bit written 0 untouched
    step(1'b0, 3'd1, 8'h00, 4'h0, 8'h80);
    step(1'b1, 3'd1, 8'h02, 4'h0, 8'h00);
    idle_rd(3'd1);
    chk("R3", {8'h00, reg_rdata}, 16'h0080);
    step(1'b1, 3'd1, 8'hFF, 4'h0, 8'h00);
    idle_rd(3'd1);
    idle_rd(3'd1);
    chk("R3", {8'h00, reg_rdata}, 16'h0000);
    chk("R7 drops", {15'h0, irq}, 16'h0000);
    // R6 mask storage limits
    step(1'b1, 3'd3, 8'hFF, 4'h0, 8'h00);
    step(1'b1, 3'd2, 8'hFF, 4'h0, 8'h00);
    idle_rd(3'd3);
    chk("R6", {8'h00, reg_rdata}, 16'h00FE);
    idle_rd(3'd2);
    chk("R6", {8'h00, reg_rdata}, 16'h00F0);
    // R7 SDIO never interrupts
    step(1'b0, 3'd1, 8'h00, 4'h0, 8'h01);
    idle_rd(3'd1); idle_rd(3'd1); idle_rd(3'd1);
    chk("R2", {8'h00, reg_rdata}, 16'h0001);
    chk("R7 sdio", {15'h0, irq}, 16'h0000);
    step(1'b1, 3'd1, 8'h01, 4'h0, 8'h00);
    // R2 byte 0 event: block done is ev_byte0[1] -> bit 5
    step(1'b0, 3'd0, 8'h00, 4'h2, 8'h00);
    idle_rd(3'd0);
    chk("R2", {8'h00, reg_rdata}, 16'h0020);
    step(1'b1, 3'd0, 8'hFF, 4'h0, 8'h00);
    // R9 unmapped
    step(1'b1, 3'd6, 8'h55, 4'h0, 8'h00);
    idle_rd(3'd6);
    chk("R9", {8'h00, reg_rdata}, 16'h0000);
    // R5 levels, two-edge delay, writes ignored
    lv = 3'b001;
    idle_rd(3'd0);
    chk("R5 delay", {8'h00, reg_rdata}, 16'h0000);
    idle_rd(3'd0);
    chk("R5", {8'h00, reg_rdata}, 16'h0002);
    step(1'b1, 3'd0, 8'hFF, 4'h0, 8'h00);
    idle_rd(3'd0);
    chk("R5", {8'h00, reg_rdata}, 16'h0002);
    // R8 configuration fields
    step(1'b1, 3'd4, 8'h3F, 4'h0, 8'h00);
    step(1'b1, 3'd5, 8'hE5, 4'h0, 8'h00);
    idle_rd(3'd5);
    chk("R8 len", {5'h0, blk_len_m1}, 16'h053F);
    chk("R8 sel", {13'h0, cd_use_dat3, cd_use_gpi, cd_pol_high}, 16'h0006);
    step(1'b1, 3'd5, 8'h10, 4'h0, 8'h00);
    idle_rd(3'd5);
    chk("R8 pol", {13'h0, cd_use_dat3, cd_use_gpi, cd_pol_high}, 16'h0001);

    // constrained random phase
    void'($urandom(32'd1234));
    for (int i = 0; i < 3000; i++) begin
      logic we;
      if ($urandom_range(15) == 0) lv = 3'($urandom());
      we = ($urandom_range(2) == 0);
      step(we, AW'($urandom()), 8'($urandom()),
           4'($urandom() & $urandom() & $urandom()),
           8'($urandom() & $urandom() & $urandom()));
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (50000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule